// File: doc/BRIEF.md
# Register Read-After-Write Consistency Monitor

This block is a passive runtime monitor. It sits beside a processor core and watches the core's retirement trace. Each retired instruction reports its sequence index, the indices of its two source registers and the values the core used for them, and the destination register index with the value it wrote. The monitor keeps its own shadow copy of the integer register file, built only from the writes that the trace reports. It checks every later source read against that shadow copy. It does not trust anything the core says about the state of its register file.

The trace carries several retirement channels in each cycle. Channels that retire in the same cycle are treated as consecutive instructions in ascending channel order. A channel therefore sees the writes of lower channels in that cycle, and it does not see the writes of higher channels. The monitor also tracks the expected sequence index and flags an index that is skipped or repeated.

On the first violation the monitor raises a sticky error flag. It records which channel failed, which register was involved, the index that channel reported, and whether the fault was a value mismatch or a sequence fault. These records stay unchanged until reset. The monitor only reads the trace and drives nothing back into the core.

Top module: `rf_raw_monitor`

## Requirements
- R1: After reset, err_flag, err_chan, err_reg, err_order and err_kind are all zero, every shadow register is unknown, and the expected sequence index is 0.
- R2: A valid channel with a nonzero destination index stores its write value in the shadow entry for that register and marks the entry known. A later read of a known register whose observed value differs from the shadow value is a mismatch (err_kind = 0), and err_reg gives the source index that failed.
- R3: A read of a nonzero register that has not been written since reset is never a mismatch, whatever value the core observed.
- R4: Register 0 always reads as zero. A read of index 0 with a nonzero observed value is a mismatch. Writes to index 0 are ignored.
- R5: Channel c sees the writes made in the same cycle by valid channels below c. It does not see writes made by channels at or above c.
- R6: The expected index starts at 0 and advances by the number of valid channels in each cycle. A valid channel must report the expected index plus the number of valid channels below it. Any other value is a sequence fault, reported with err_kind = 1 and err_reg = 0.
- R7: Once set, err_flag stays at 1 until reset. err_chan, err_reg, err_order and err_kind keep the values of the first fault.
- R8: When several faults occur in one cycle, the lowest failing channel is recorded. Within one channel, a sequence fault takes priority over an rs1 mismatch, and an rs1 mismatch takes priority over an rs2 mismatch.
- R9: A channel whose valid bit is 0 is ignored: its fields cause no write, no fault and no advance of the index.
- R10: When several channels write the same register in one cycle, the highest such channel's value is the one that later reads are checked against.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trc_valid | input | NCH | One retirement valid bit per channel |
| trc_order | input | NCH*OW | Instruction sequence index per channel |
| trc_rs1_idx | input | NCH*IW | First source register index per channel |
| trc_rs1_val | input | NCH*XLEN | Value observed for the first source |
| trc_rs2_idx | input | NCH*IW | Second source register index per channel |
| trc_rs2_val | input | NCH*XLEN | Value observed for the second source |
| trc_rd_idx | input | NCH*IW | Destination register index per channel |
| trc_rd_val | input | NCH*XLEN | Value written to the destination |
| err_flag | output | 1 | Sticky fault indicator |
| err_chan | output | CW | Channel of the first fault |
| err_reg | output | IW | Register of the first fault (0 for a sequence fault) |
| err_order | output | OW | Sequence index reported by the failing channel |
| err_kind | output | 1 | 0 = value mismatch, 1 = sequence fault |

## Verification
The assertions check the cycle-level rules on every clock. The flag is sticky and the recorded fault fields stay frozen once it is set. An idle cycle cannot raise the flag. A nonzero read of register 0 on the first channel always raises it. A sequence fault always reports register 0.

Some behaviour depends on history, and only the bench's scenarios can show it. This covers the shadow contents across many cycles, the visibility of writes between channels within one cycle, the rule that the highest channel wins on a shared destination, the treatment of never-written registers, and the priority between simultaneous faults. The bench checks these against a reference model that applies each channel in turn.

// File: rtl/rf_raw_monitor.sv
module rf_raw_monitor #(
  parameter int NCH  = 2,
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter int OW   = 16,
  localparam int IW  = $clog2(NREG),
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     trc_valid,
  input  logic [NCH*OW-1:0]  trc_order,
  input  logic [NCH*IW-1:0]  trc_rs1_idx,
  input  logic [NCH*XLEN-1:0] trc_rs1_val,
  input  logic [NCH*IW-1:0]  trc_rs2_idx,
  input  logic [NCH*XLEN-1:0] trc_rs2_val,
  input  logic [NCH*IW-1:0]  trc_rd_idx,
  input  logic [NCH*XLEN-1:0] trc_rd_val,
  output logic               err_flag,
  output logic [CW-1:0]      err_chan,
  output logic [IW-1:0]      err_reg,
  output logic [OW-1:0]      err_order,
  output logic               err_kind
);

  logic [XLEN-1:0] shadow [NREG];
  logic [NREG-1:0] known;
  logic [OW-1:0]   next_ord;
  logic [OW-1:0]   next_ord_d;

  logic [NCH-1:0]  ch_bad;
  logic [NCH-1:0]  ch_seq;
  logic [IW-1:0]   ch_reg [NCH];

  logic [CW-1:0]   sel_ch;
  logic            any_bad;

  always_comb begin
    logic [OW-1:0]   cnt;
    logic [IW-1:0]   s1, s2, dp;
    logic [XLEN-1:0] o1, o2, v1, v2;
    logic            k1, k2, b1, b2, sq;
    cnt = next_ord;
    for (int c = 0; c < NCH; c++) begin
      s1 = trc_rs1_idx[c*IW +: IW];
      s2 = trc_rs2_idx[c*IW +: IW];
      o1 = trc_rs1_val[c*XLEN +: XLEN];
      o2 = trc_rs2_val[c*XLEN +: XLEN];
      v1 = shadow[s1];
      k1 = known[s1];
      v2 = shadow[s2];
      k2 = known[s2];
      for (int p = 0; p < NCH; p++) begin
        dp = trc_rd_idx[p*IW +: IW];
        if (p < c && trc_valid[p] && dp != '0) begin
          if (dp == s1) begin
            v1 = trc_rd_val[p*XLEN +: XLEN];
            k1 = 1'b1;
          end
          if (dp == s2) begin
            v2 = trc_rd_val[p*XLEN +: XLEN];
            k2 = 1'b1;
          end
        end
      end
      b1 = (s1 == '0) ? (o1 != '0) : (k1 && (v1 != o1));
      b2 = (s2 == '0) ? (o2 != '0) : (k2 && (v2 != o2));
      sq = trc_order[c*OW +: OW] != cnt;
      ch_seq[c] = trc_valid[c] && sq;
      ch_bad[c] = trc_valid[c] && (sq || b1 || b2);
      ch_reg[c] = sq ? '0 : (b1 ? s1 : s2);
      if (trc_valid[c]) cnt = cnt + 1'b1;
    end
    next_ord_d = cnt;
  end

  always_comb begin
    sel_ch = '0;
    for (int c = NCH - 1; c >= 0; c--)
      if (ch_bad[c]) sel_ch = CW'(c);
  end

  assign any_bad = |ch_bad;

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++)
      if (trc_valid[c] && trc_rd_idx[c*IW +: IW] != '0)
        shadow[trc_rd_idx[c*IW +: IW]] <= trc_rd_val[c*XLEN +: XLEN];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      known     <= '0;
      next_ord  <= '0;
      err_flag  <= 1'b0;
      err_chan  <= '0;
      err_reg   <= '0;
      err_order <= '0;
      err_kind  <= 1'b0;
    end else begin
      for (int c = 0; c < NCH; c++)
        if (trc_valid[c] && trc_rd_idx[c*IW +: IW] != '0)
          known[trc_rd_idx[c*IW +: IW]] <= 1'b1;
      next_ord <= next_ord_d;
      if (!err_flag && any_bad) begin
        err_flag  <= 1'b1;
        err_chan  <= sel_ch;
        err_reg   <= ch_reg[sel_ch];
        err_order <= trc_order[sel_ch*OW +: OW];
        err_kind  <= ch_seq[sel_ch];
      end
    end
  end

endmodule

// File: rtl/rf_raw_monitor_sva.sv
module rf_raw_monitor_sva #(
  parameter int NCH  = 2,
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter int OW   = 16,
  localparam int IW  = $clog2(NREG),
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NCH-1:0]     trc_valid,
  input logic [NCH*IW-1:0]  trc_rs1_idx,
  input logic [NCH*XLEN-1:0] trc_rs1_val,
  input logic               err_flag,
  input logic [CW-1:0]      err_chan,
  input logic [IW-1:0]      err_reg,
  input logic [OW-1:0]      err_order,
  input logic               err_kind
);

  assert_sticky_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  assert_frozen_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> ($stable(err_chan) && $stable(err_reg) && $stable(err_order) && $stable(err_kind)));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_flag && trc_valid == '0) |=> !err_flag);

  assert_zero_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_flag && trc_valid[0] && trc_rs1_idx[IW-1:0] == '0 && trc_rs1_val[XLEN-1:0] != '0) |=> err_flag);

  assert_seq_no_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && err_kind) |-> err_reg == '0);

endmodule

bind rf_raw_monitor rf_raw_monitor_sva #(.NCH(NCH), .XLEN(XLEN), .NREG(NREG), .OW(OW)) u_sva (
  .clk(clk), .rst_n(rst_n), .trc_valid(trc_valid),
  .trc_rs1_idx(trc_rs1_idx), .trc_rs1_val(trc_rs1_val),
  .err_flag(err_flag), .err_chan(err_chan), .err_reg(err_reg),
  .err_order(err_order), .err_kind(err_kind)
);

// File: tb/rf_raw_monitor_tb.sv
module rf_raw_monitor_tb;
  localparam int NCH = 2, XLEN = 32, NREG = 32, OW = 16, IW = 5, CW = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NCH-1:0]      trc_valid;
  logic [NCH*OW-1:0]   trc_order;
  logic [NCH*IW-1:0]   trc_rs1_idx, trc_rs2_idx, trc_rd_idx;
  logic [NCH*XLEN-1:0] trc_rs1_val, trc_rs2_val, trc_rd_val;
  logic                err_flag, err_kind;
  logic [CW-1:0]       err_chan;
  logic [IW-1:0]       err_reg;
  logic [OW-1:0]       err_order;

  logic            d_v  [NCH];
  logic [OW-1:0]   d_ord[NCH];
  logic [IW-1:0]   d_rs1[NCH], d_rs2[NCH], d_rd[NCH];
  logic [XLEN-1:0] d_v1 [NCH], d_v2 [NCH], d_wv[NCH];

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      trc_valid[c]               = d_v[c];
      trc_order[c*OW +: OW]      = d_ord[c];
      trc_rs1_idx[c*IW +: IW]    = d_rs1[c];
      trc_rs2_idx[c*IW +: IW]    = d_rs2[c];
      trc_rd_idx[c*IW +: IW]     = d_rd[c];
      trc_rs1_val[c*XLEN +: XLEN] = d_v1[c];
      trc_rs2_val[c*XLEN +: XLEN] = d_v2[c];
      trc_rd_val[c*XLEN +: XLEN]  = d_wv[c];
    end
  end

  rf_raw_monitor #(.NCH(NCH), .XLEN(XLEN), .NREG(NREG), .OW(OW)) u_dut (
    .clk(clk), .rst_n(rst_n), .trc_valid(trc_valid), .trc_order(trc_order),
    .trc_rs1_idx(trc_rs1_idx), .trc_rs1_val(trc_rs1_val),
    .trc_rs2_idx(trc_rs2_idx), .trc_rs2_val(trc_rs2_val),
    .trc_rd_idx(trc_rd_idx), .trc_rd_val(trc_rd_val),
    .err_flag(err_flag), .err_chan(err_chan), .err_reg(err_reg),
    .err_order(err_order), .err_kind(err_kind)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  logic [XLEN-1:0] m_val [NREG];
  bit              m_kn  [NREG];
  logic [OW-1:0]   m_next;
  bit              e_flag, e_kind;
  logic [CW-1:0]   e_chan;
  logic [IW-1:0]   e_reg;
  logic [OW-1:0]   e_ord;

  task automatic check(string req, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit read_bad(logic [IW-1:0] idx, logic [XLEN-1:0] v);
    if (idx == 0) return v != 0;
    return m_kn[idx] && (m_val[idx] != v);
  endfunction

  task automatic model_apply();
    int n = 0;
    for (int c = 0; c < NCH; c++) begin
      if (d_v[c]) begin
        bit bad = 0, kind = 0;
        logic [IW-1:0] rg = 0;
        if (d_ord[c] != m_next + OW'(n)) begin bad = 1; kind = 1; rg = 0; end
        else if (read_bad(d_rs1[c], d_v1[c])) begin bad = 1; rg = d_rs1[c]; end
        else if (read_bad(d_rs2[c], d_v2[c])) begin bad = 1; rg = d_rs2[c]; end
        if (bad && !e_flag) begin
          e_flag = 1; e_kind = kind; e_chan = CW'(c); e_reg = rg; e_ord = d_ord[c];
        end
        if (d_rd[c] != 0) begin m_val[d_rd[c]] = d_wv[c]; m_kn[d_rd[c]] = 1; end
        n++;
      end
    end
    m_next = m_next + OW'(n);
  endtask

  task automatic compare_model();
    check("R2", "err_flag", err_flag, e_flag);
    if (e_flag) begin
      check("R8", "err_chan", err_chan, e_chan);
      check("R2", "err_reg", err_reg, e_reg);
      check("R6", "err_order", err_order, e_ord);
      check("R6", "err_kind", err_kind, e_kind);
    end
  endtask

  task automatic clear_all();
    for (int c = 0; c < NCH; c++) begin
      d_v[c] = 0; d_ord[c] = 0; d_rs1[c] = 0; d_rs2[c] = 0; d_rd[c] = 0;
      d_v1[c] = 0; d_v2[c] = 0; d_wv[c] = 0;
    end
  endtask

  task automatic set_ch(int c, int ord, int rs1, logic [XLEN-1:0] v1,
                        int rs2, logic [XLEN-1:0] v2, int rd, logic [XLEN-1:0] wv);
    d_v[c] = 1; d_ord[c] = OW'(ord); d_rs1[c] = IW'(rs1); d_v1[c] = v1;
    d_rs2[c] = IW'(rs2); d_v2[c] = v2; d_rd[c] = IW'(rd); d_wv[c] = wv;
  endtask

  task automatic do_reset();
    clear_all();
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    for (int r = 0; r < NREG; r++) begin m_val[r] = 0; m_kn[r] = 0; end
    m_next = 0; e_flag = 0; e_kind = 0; e_chan = 0; e_reg = 0; e_ord = 0;
  endtask

  task automatic run_cycle();
    model_apply();
    @(negedge clk);
    compare_model();
    clear_all();
  endtask

  task automatic gen_random(bit corrupt);
    logic [XLEN-1:0] lv [NREG];
    bit              lk [NREG];
    int n = 0;
    for (int r = 0; r < NREG; r++) begin lv[r] = m_val[r]; lk[r] = m_kn[r]; end
    for (int c = 0; c < NCH; c++) begin
      d_v[c] = ($urandom % 4) != 0;
      d_ord[c] = m_next + OW'(n);
      if (corrupt && ($urandom % 300) == 0) d_ord[c] = d_ord[c] + 1'b1;
      d_rs1[c] = IW'(($urandom % 2) ? $urandom % 8 : $urandom % NREG);
      d_rs2[c] = IW'(($urandom % 2) ? $urandom % 8 : $urandom % NREG);
      d_v1[c] = (d_rs1[c] == 0) ? '0 : (lk[d_rs1[c]] ? lv[d_rs1[c]] : $urandom);
      d_v2[c] = (d_rs2[c] == 0) ? '0 : (lk[d_rs2[c]] ? lv[d_rs2[c]] : $urandom);
      if (corrupt && ($urandom % 150) == 0) d_v1[c] ^= (32'h1 << ($urandom % 32));
      if (corrupt && ($urandom % 150) == 0) d_v2[c] ^= (32'h1 << ($urandom % 32));
      d_rd[c] = IW'(($urandom % 2) ? $urandom % 8 : $urandom % NREG);
      d_wv[c] = $urandom;
      if (d_v[c]) begin
        if (d_rd[c] != 0) begin lv[d_rd[c]] = d_wv[c]; lk[d_rd[c]] = 1; end
        n++;
      end
    end
  endtask

  task automatic expect_err(string req, int ch, int rg, int ord, int kind);
    check(req, "err_flag", err_flag, 1);
    check(req, "err_chan", err_chan, ch);
    check(req, "err_reg", err_reg, rg);
    check(req, "err_order", err_order, ord);
    check(req, "err_kind", err_kind, kind);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    @(negedge clk);
    // R1 reset state
    check("R1", "err_flag", err_flag, 0);
    check("R1", "err_chan", err_chan, 0);
    check("R1", "err_reg", err_reg, 0);
    check("R1", "err_order", err_order, 0);
    check("R1", "err_kind", err_kind, 0);

    // R3 unwritten reads unchecked, R2 write then read
    set_ch(0, 0, 5, 32'hDEAD, 6, 32'hBEEF, 0, 0); run_cycle();
    check("R3", "err_flag", err_flag, 0);
    set_ch(0, 1, 0, 0, 0, 0, 5, 32'hA5A5); run_cycle();
    set_ch(0, 2, 5, 32'hA5A5, 0, 0, 0, 0); run_cycle();
    check("R2", "err_flag", err_flag, 0);
    set_ch(0, 3, 0, 0, 5, 32'hB0B0, 0, 0); run_cycle();
    expect_err("R2", 0, 5, 3, 0);

    // R4 register zero
    do_reset();
    set_ch(0, 0, 0, 0, 0, 0, 0, 32'd123); run_cycle();
    set_ch(0, 1, 0, 0, 0, 0, 0, 0); run_cycle();
    check("R4", "err_flag", err_flag, 0);
    set_ch(0, 2, 0, 0, 0, 32'd123, 0, 0); run_cycle();
    expect_err("R4", 0, 0, 2, 0);

    // R5 same-cycle visibility, R10 highest channel wins
    do_reset();
    set_ch(0, 0, 0, 0, 0, 0, 7, 32'h77); set_ch(1, 1, 7, 32'h77, 0, 0, 0, 0); run_cycle();
    check("R5", "err_flag", err_flag, 0);
    set_ch(0, 2, 0, 0, 0, 0, 8, 32'h1111); run_cycle();
    set_ch(0, 3, 8, 32'h1111, 0, 0, 0, 0); set_ch(1, 4, 0, 0, 0, 0, 8, 32'h2222); run_cycle();
    check("R5", "err_flag", err_flag, 0);
    set_ch(0, 5, 8, 32'h2222, 0, 0, 0, 0); run_cycle();
    check("R5", "err_flag", err_flag, 0);
    set_ch(0, 6, 0, 0, 0, 0, 9, 32'd1); set_ch(1, 7, 0, 0, 0, 0, 9, 32'd2); run_cycle();
    set_ch(0, 8, 9, 32'd2, 0, 0, 0, 0); run_cycle();
    check("R10", "err_flag", err_flag, 0);
    set_ch(0, 9, 9, 32'd1, 0, 0, 0, 0); run_cycle();
    expect_err("R10", 0, 9, 9, 0);

    // R9 invalid channel ignored, R6 sequence
    do_reset();
    set_ch(0, 55, 3, 32'h9, 3, 32'h9, 3, 32'hBAD); d_v[0] = 0;
    set_ch(1, 0, 0, 0, 0, 0, 3, 32'hAAAA); run_cycle();
    check("R9", "err_flag", err_flag, 0);
    set_ch(0, 77, 0, 32'h5, 0, 32'h5, 3, 32'hBBBB); d_v[0] = 0; run_cycle();
    check("R9", "err_flag", err_flag, 0);
    set_ch(0, 1, 3, 32'hAAAA, 0, 0, 0, 0); run_cycle();
    check("R9", "err_flag", err_flag, 0);
    set_ch(0, 2, 0, 0, 0, 0, 0, 0); set_ch(1, 4, 0, 0, 0, 0, 0, 0); run_cycle();
    expect_err("R6", 1, 0, 4, 1);

    // R8 lowest channel and rs1 priority, R7 sticky
    do_reset();
    set_ch(0, 0, 0, 0, 0, 0, 1, 32'd10); set_ch(1, 1, 0, 0, 0, 0, 2, 32'd20); run_cycle();
    set_ch(0, 2, 1, 32'd11, 0, 0, 0, 0); set_ch(1, 3, 2, 32'd21, 0, 0, 0, 0); run_cycle();
    expect_err("R8", 0, 1, 2, 0);
    set_ch(0, 4, 0, 0, 2, 32'd99, 0, 0); run_cycle();
    expect_err("R7", 0, 1, 2, 0);
    set_ch(0, 9, 0, 0, 0, 0, 0, 0); run_cycle();
    expect_err("R7", 0, 1, 2, 0);
    do_reset();
    set_ch(0, 0, 0, 0, 0, 0, 1, 32'd10); set_ch(1, 1, 0, 0, 0, 0, 2, 32'd20); run_cycle();
    set_ch(0, 2, 2, 32'd5, 1, 32'd6, 0, 0); run_cycle();
    expect_err("R8", 0, 2, 2, 0);

    // random episodes against the reference model
    for (int ep = 0; ep < 24; ep++) begin
      do_reset();
      for (int cy = 0; cy < 250; cy++) begin
        gen_random(ep >= 8);
        run_cycle();
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule